// File: doc/BRIEF.md
# I2C Master Byte Receiver

This block is the receive half of an I2C bus master. Software writes a five-bit sequence-control word. When only the receive-enable bit of that word is set, the engine runs eight SCL clock pulses and leaves SDA released. It samples the slave's data bit near the end of each high phase and assembles the byte most significant bit first. On the eighth falling edge of SCL the byte is handed to a receive buffer, the receive-enable bit drops, and a one-cycle interrupt pulse is raised.

Around the shifter sit a buffer-full flag, an overflow flag, a write-collision flag and a transmit buffer register. A read strobe on the receive buffer frees it. Once a byte has been dropped because the buffer was still full, the overflow flag stays set. A transmit-buffer write that arrives while a byte is being received is refused and sets the write-collision flag. While a reception is running, the sequence-control bits cannot be changed. Each SCL phase lasts `HALF_CLKS` system clocks.

Top module: `i2c_rx_master`

## Requirements
- R1: After reset, SCL is high, the control word, both buffers, all three flags and the interrupt are zero.
- R2: An accepted start holds SCL low for HALF_CLKS cycles and then high for HALF_CLKS cycles, eight times. The final falling edge comes exactly 16*HALF_CLKS cycles after the start edge. SCL is high again HALF_CLKS cycles later and stays high while idle.
- R3: SDA is sampled in the last system cycle of each SCL high phase, most significant bit first. On the eighth falling edge the byte enters the receive buffer and receive-enable (control bit 3) clears.
- R4: On that same edge the buffer-full flag sets and the interrupt output is high for exactly one cycle.
- R5: A one-cycle read strobe on the receive buffer clears the buffer-full flag.
- R6: A byte that completes while buffer-full is set and no read is strobed sets the overflow flag. The byte is discarded and the buffer keeps its old value.
- R7: A set overflow flag does not stop later receptions. After a read, the next byte is stored normally and the overflow flag stays set.
- R8: A transmit-buffer write while a reception is running sets the write-collision flag and leaves the transmit buffer unchanged. When idle, the write updates the buffer and leaves the flag untouched.
- R9: While a reception is running, control-word writes change none of the five bits.
- R10: A write with bit 3 set is refused as a start in two cases: when the stored control word is nonzero, or when the written word has any other bit set. In that case bit 3 is stored as zero, the other written bits are stored, and SCL stays high.
- R11: Overflow and write-collision are sticky. A flag-port write clears overflow when data bit 0 is zero and clears write-collision when data bit 1 is zero. Writing ones changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word write data, bit 3 is receive-enable |
| ctl_q | output | 5 | Current control word |
| flag_we | input | 1 | Flag clear write strobe |
| flag_wdata | input | 2 | Bit 0 zero clears overflow, bit 1 zero clears write-collision |
| tx_we | input | 1 | Transmit buffer write strobe |
| tx_wdata | input | DATA_W | Transmit buffer write data |
| tx_data | output | DATA_W | Transmit buffer contents |
| rx_re | input | 1 | Receive buffer read strobe |
| rx_data | output | DATA_W | Receive buffer contents |
| rx_full | output | 1 | Receive buffer full flag |
| rx_ovf | output | 1 | Overflow flag |
| tx_wcol | output | 1 | Write-collision flag |
| irq | output | 1 | One-cycle completion pulse |
| scl | output | 1 | Bus clock driven by the master |
| sda_in | input | 1 | Sampled bus data line |

## Verification
The assertions assume that `sda_in` is stable for the whole SCL high phase. They also assume that software strobes a read at most once per completed byte and never in the same cycle as a completion. The stimulus changes SDA only while it sees SCL low. It places reads and flag writes only in idle gaps between receptions. It injects the collision and lock attempts at a fixed point in the middle of a reception, so none of them coincides with the completion edge.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    localparam int SEQ_W    = 5;
    localparam int RCEN_BIT = 3;
    localparam int FLG_OVF  = 0;
    localparam int FLG_WCOL = 1;
    localparam int FLG_W    = 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH,
        PH_TAIL
    } phase_e;

    typedef struct packed {
        logic wcol;
        logic ovf;
        logic full;
    } flags_t;

    // A start is legal only from an all-zero control word and a write
    // that carries no other sequence bit.
    function automatic logic start_legal(input logic [SEQ_W-1:0] cur,
                                         input logic [SEQ_W-1:0] wr);
        logic [SEQ_W-1:0] others;
        others = wr;
        others[RCEN_BIT] = 1'b0;
        return (cur == '0) && (others == '0);
    endfunction

endpackage

// File: rtl/i2c_rx_ctl.sv
module i2c_rx_ctl
    import i2c_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEQ_W-1:0] wr_data,
    input  logic             busy,
    input  logic             done,
    output logic             start,
    output logic [SEQ_W-1:0] seq_q
);

    logic wr_open;

    always_comb begin
        wr_open = wr_en && !busy;
        start   = wr_open && wr_data[RCEN_BIT] && start_legal(seq_q, wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else begin
            if (done) begin
                seq_q[RCEN_BIT] <= 1'b0;
            end
            if (wr_open) begin
                seq_q           <= wr_data;
                seq_q[RCEN_BIT] <= start;
            end
        end
    end

    a_r3_rcen_drop: assert property (@(posedge clk) disable iff (rst)
        done |=> !seq_q[RCEN_BIT]);

    a_r9_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy && !done) |=> (seq_q == $past(seq_q)));

    a_r10_refused: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && (seq_q != '0)) |=> !seq_q[RCEN_BIT]);

endmodule

// File: rtl/i2c_rx_shift.sv
module i2c_rx_shift
    import i2c_rx_pkg::*;
#(
    parameter int HALF_CLKS = 4,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sda_in,
    output logic              scl,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] byte_out
);

    localparam int CNT_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CLKS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    phase_e            ph;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bidx;
    logic [DATA_W-2:0] sh;
    logic              ph_end;

    always_comb begin
        ph_end   = (cnt == CNT_LAST);
        busy     = (ph != PH_IDLE);
        byte_out = {sh, sda_in};
        done     = (ph == PH_HIGH) && ph_end && (bidx == BIT_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            bidx <= '0;
            sh   <= '0;
            scl  <= 1'b1;
        end else begin
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph   <= PH_LOW;
                        scl  <= 1'b0;
                        cnt  <= '0;
                        bidx <= '0;
                    end
                end
                PH_LOW: begin
                    if (ph_end) begin
                        ph  <= PH_HIGH;
                        scl <= 1'b1;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (ph_end) begin
                        sh  <= byte_out[DATA_W-2:0];
                        scl <= 1'b0;
                        cnt <= '0;
                        if (bidx == BIT_LAST) begin
                            ph <= PH_TAIL;
                        end else begin
                            bidx <= bidx + BIT_W'(1);
                            ph   <= PH_LOW;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    if (ph_end) begin
                        ph  <= PH_IDLE;
                        scl <= 1'b1;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> scl);

    a_r2_fall_on_done: assert property (@(posedge clk) disable iff (rst)
        done |=> (!scl && busy));

endmodule

// File: rtl/i2c_rx_buf.sv
module i2c_rx_buf
    import i2c_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              busy,
    input  logic              rd_en,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              flag_we,
    input  logic [FLG_W-1:0]  flag_wdata,
    output logic [DATA_W-1:0] rx_q,
    output logic [DATA_W-1:0] tx_q,
    output flags_t            fl,
    output logic              irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
            tx_q <= '0;
            fl   <= '0;
            irq  <= 1'b0;
        end else begin
            irq <= done;

            if (flag_we && !flag_wdata[FLG_OVF]) begin
                fl.ovf <= 1'b0;
            end
            if (flag_we && !flag_wdata[FLG_WCOL]) begin
                fl.wcol <= 1'b0;
            end

            if (done) begin
                if (fl.full && !rd_en) begin
                    fl.ovf <= 1'b1;
                end else begin
                    rx_q    <= byte_in;
                    fl.full <= 1'b1;
                end
            end else if (rd_en) begin
                fl.full <= 1'b0;
            end

            if (tx_we) begin
                if (busy) begin
                    fl.wcol <= 1'b1;
                end else begin
                    tx_q <= tx_wdata;
                end
            end
        end
    end

    a_r4_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r4_full_on_done: assert property (@(posedge clk) disable iff (rst)
        done |=> (fl.full && irq));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !done) |=> !fl.full);

    a_r6_keep_old: assert property (@(posedge clk) disable iff (rst)
        (done && fl.full && !rd_en) |=> (fl.ovf && $stable(rx_q)));

    a_r8_collision: assert property (@(posedge clk) disable iff (rst)
        (tx_we && busy) |=> (fl.wcol && $stable(tx_q)));

    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (fl.ovf && !(flag_we && !flag_wdata[FLG_OVF])) |=> fl.ovf);

endmodule

// File: rtl/i2c_rx_master.sv
module i2c_rx_master
    import i2c_rx_pkg::*;
#(
    parameter int HALF_CLKS = 4,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [SEQ_W-1:0]  ctl_wdata,
    output logic [SEQ_W-1:0]  ctl_q,
    input  logic              flag_we,
    input  logic [FLG_W-1:0]  flag_wdata,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_wdata,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_re,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_ovf,
    output logic              tx_wcol,
    output logic              irq,
    output logic              scl,
    input  logic              sda_in
);

    logic              start;
    logic              busy;
    logic              done;
    logic [DATA_W-1:0] byte_w;
    flags_t            fl;

    i2c_rx_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl_we),
        .wr_data (ctl_wdata),
        .busy    (busy),
        .done    (done),
        .start   (start),
        .seq_q   (ctl_q)
    );

    i2c_rx_shift #(
        .HALF_CLKS (HALF_CLKS),
        .DATA_W    (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .sda_in   (sda_in),
        .scl      (scl),
        .busy     (busy),
        .done     (done),
        .byte_out (byte_w)
    );

    i2c_rx_buf #(
        .DATA_W (DATA_W)
    ) u_buf (
        .clk        (clk),
        .rst        (rst),
        .done       (done),
        .byte_in    (byte_w),
        .busy       (busy),
        .rd_en      (rx_re),
        .tx_we      (tx_we),
        .tx_wdata   (tx_wdata),
        .flag_we    (flag_we),
        .flag_wdata (flag_wdata),
        .rx_q       (rx_data),
        .tx_q       (tx_data),
        .fl         (fl),
        .irq        (irq)
    );

    assign rx_full = fl.full;
    assign rx_ovf  = fl.ovf;
    assign tx_wcol = fl.wcol;

endmodule

// File: tb/i2c_rx_master_bench.sv
`timescale 1ns/1ps
module i2c_rx_master_bench;

    localparam int H  = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctl_we = 1'b0;
    logic [4:0]    ctl_wdata = '0;
    logic [4:0]    ctl_q;
    logic          flag_we = 1'b0;
    logic [1:0]    flag_wdata = 2'b11;
    logic          tx_we = 1'b0;
    logic [DW-1:0] tx_wdata = '0;
    logic [DW-1:0] tx_data;
    logic          rx_re = 1'b0;
    logic [DW-1:0] rx_data;
    logic          rx_full, rx_ovf, tx_wcol, irq, scl;
    logic          sda_in = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    i2c_rx_master #(.HALF_CLKS(H), .DATA_W(DW)) u_i2c_rx_master (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_q(ctl_q), .flag_we(flag_we), .flag_wdata(flag_wdata),
        .tx_we(tx_we), .tx_wdata(tx_wdata), .tx_data(tx_data),
        .rx_re(rx_re), .rx_data(rx_data), .rx_full(rx_full),
        .rx_ovf(rx_ovf), .tx_wcol(tx_wcol), .irq(irq), .scl(scl),
        .sda_in(sda_in)
    );

    // Expected control word after an idle write, from R10.
    function automatic logic [4:0] exp_ctl(input logic [4:0] cur, input logic [4:0] wr);
        logic [4:0] r;
        r = wr;
        if (wr[3] && !(cur == 5'd0 && (wr & 5'b10111) == 5'd0)) r[3] = 1'b0;
        return r;
    endfunction

    function automatic int exp_period();
        return 16 * H;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [4:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_flag(input logic [1:0] v);
        @(negedge clk); flag_we = 1'b1; flag_wdata = v;
        @(negedge clk); flag_we = 1'b0; flag_wdata = 2'b11;
    endtask

    task automatic wr_tx(input logic [DW-1:0] v);
        @(negedge clk); tx_we = 1'b1; tx_wdata = v;
        @(negedge clk); tx_we = 1'b0;
    endtask

    task automatic rd_rx();
        @(negedge clk); rx_re = 1'b1;
        @(negedge clk); rx_re = 1'b0;
    endtask

    // Start a reception and play the slave; inject 1 = tx write, 2 = ctl write.
    task automatic rx_byte(input logic [DW-1:0] b, input int inject);
        int k = 0;
        int nr = 0;
        logic prev = 1'b0;
        wr_ctl(5'b01000);
        chk("R2 rcen stored on start", ctl_q, 5'b01000);
        while (!irq && k < 1000) begin
            if (scl && !prev) nr++;
            prev = scl;
            if (!scl && nr < DW) sda_in = b[DW-1-nr];
            tx_we = (inject == 1 && k == 5);
            tx_wdata = 8'hC3;
            ctl_we = (inject == 2 && k == 5);
            ctl_wdata = 5'h17;
            @(negedge clk);
            k++;
        end
        tx_we = 1'b0;
        ctl_we = 1'b0;
        chk("R2 cycles start to last fall", k, exp_period());
        chk("R2 eight SCL pulses", nr, DW);
        chk("R4 irq high at completion", irq, 1);
        chk("R4 full set at completion", rx_full, 1);
        chk("R3 rcen cleared at completion", ctl_q[3], 0);
        chk("R2 scl low after last fall", scl, 0);
        @(negedge clk);
        chk("R4 irq one cycle", irq, 0);
        repeat (H - 1) @(negedge clk);
        chk("R2 scl high after tail", scl, 1);
    endtask

    initial begin
        logic [DW-1:0] b, a, c;
        int saw_low;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 scl reset", scl, 1);
        chk("R1 ctl reset", ctl_q, 0);
        chk("R1 rx reset", rx_data, 0);
        chk("R1 tx reset", tx_data, 0);
        chk("R1 flags reset", {rx_full, rx_ovf, tx_wcol, irq}, 0);

        // Random bytes, each read back and freed.
        for (int i = 0; i < 6; i++) begin
            b = DW'($urandom);
            rx_byte(b, 0);
            chk("R3 byte msb first", rx_data, b);
            rd_rx();
            chk("R5 read clears full", rx_full, 0);
            chk("R5 no overflow", rx_ovf, 0);
        end

        // Directed corner bytes.
        rx_byte(8'h80, 0); chk("R3 msb only", rx_data, 8'h80); rd_rx();
        rx_byte(8'h01, 0); chk("R3 lsb only", rx_data, 8'h01); rd_rx();

        // Overflow: second byte lost.
        a = 8'hA5; c = 8'h3C;
        rx_byte(a, 0);
        rx_byte(8'h5A, 0);
        chk("R6 overflow set", rx_ovf, 1);
        chk("R6 old byte kept", rx_data, a);
        chk("R6 full still set", rx_full, 1);
        rd_rx();
        chk("R7 full clear after read", rx_full, 0);
        rx_byte(c, 0);
        chk("R7 next byte stored", rx_data, c);
        chk("R7 overflow stays", rx_ovf, 1);
        rd_rx();

        // Sticky flags.
        wr_flag(2'b11);
        chk("R11 writing one keeps ovf", rx_ovf, 1);
        wr_flag(2'b10);
        chk("R11 zero clears ovf", rx_ovf, 0);

        // Write collision.
        wr_tx(8'h5A);
        chk("R8 idle tx write", tx_data, 8'h5A);
        chk("R8 idle no collision", tx_wcol, 0);
        b = DW'($urandom);
        rx_byte(b, 1);
        chk("R8 collision flagged", tx_wcol, 1);
        chk("R8 tx unchanged", tx_data, 8'h5A);
        chk("R8 byte still received", rx_data, b);
        rd_rx();
        wr_flag(2'b11);
        chk("R11 writing one keeps wcol", tx_wcol, 1);
        wr_flag(2'b01);
        chk("R11 zero clears wcol", tx_wcol, 0);

        // Control lock during reception.
        b = DW'($urandom);
        rx_byte(b, 2);
        chk("R9 ctl write ignored while busy", ctl_q, 5'd0);
        chk("R9 byte intact", rx_data, b);
        rd_rx();

        // Refused starts.
        wr_ctl(5'b00001);
        chk("R10 plain bit stored", ctl_q, exp_ctl(5'd0, 5'b00001));
        wr_ctl(5'b01001);
        chk("R10 rcen refused with bit0 set", ctl_q, exp_ctl(5'b00001, 5'b01001));
        saw_low = 0;
        for (int j = 0; j < 4 * H; j++) begin
            @(negedge clk);
            if (!scl) saw_low = 1;
        end
        chk("R10 no clocks when refused", saw_low, 0);
        chk("R10 no byte when refused", rx_full, 0);
        wr_ctl(5'b00000);
        wr_ctl(5'b01100);
        chk("R10 rcen refused with extra bit", ctl_q, exp_ctl(5'd0, 5'b01100));
        saw_low = 0;
        for (int j = 0; j < 4 * H; j++) begin
            @(negedge clk);
            if (!scl) saw_low = 1;
        end
        chk("R10 no clocks on mixed write", saw_low, 0);
        wr_ctl(5'b00000);
        rx_byte(8'hE7, 0);
        chk("R10 legal start after clear", rx_data, 8'hE7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule